// File: doc/BRIEF.md
# I2C Debug Register Target

This block lets an external I2C host read and write a bank of on-chip debug registers. It samples the asynchronous SCL and SDA pins through synchronizer chains on the system clock. It detects START, repeated START and STOP conditions and matches a 7-bit device address. It then decodes a command byte and moves data between the bus and a simple parallel register port. SDA is driven only by pulling it low through an open-drain enable. The bus pins are never driven high.

A single command byte selects the register and the transfer width. A write names the register, and the target then accepts one or two data bytes. A read first sends the command in a write-addressed phase. After a repeated START, or after a STOP and a new START, the host re-addresses the target with the read flag, and the target returns one or two bytes. A 16-bit value always crosses the bus low byte first.

Top module: `dbgreg_i2c_target`

## Requirements
- R1: START, STOP and data bits are recognised correctly when SCL and SDA each reach the pins with an independent extra delay of up to one system clock.
- R2: The device address 0x45 is acknowledged whether the R/W bit (bit 0 of the address byte) is 0 or 1.
- R3: Any other address (apart from R4's) gets no acknowledge. The target then acknowledges nothing and issues no strobe until the next START.
- R4: The broadcast address 0x67 is acknowledged with R/W=0, and the write that follows is performed. With R/W=1 it is not acknowledged and no read strobe occurs.
- R5: Command byte layout: bit 7 = 1 means write and 0 means read. Bit 6 = 0 selects a two-byte data phase and 1 selects one byte. Bits 5:0 are driven on `reg_addr`, which holds its value after the transaction.
- R6: In a write, the first data byte is the low byte. `reg_wdata` becomes {high, low} for two bytes, or {8'h00, byte} for one byte. `reg_wr` pulses once after the ninth clock of the last data byte. Bytes after the data phase are not acknowledged.
- R7: Every byte travels most-significant bit first, and each received bit is taken at the rising edge of SCL.
- R8: In a read addressed with R/W=1, `reg_rd` pulses and `reg_rdata` is captured in that same cycle. The target then sends the low byte and, for a two-byte read, the high byte, both MSB first.
- R9: After the last data byte of a read, or after a host NACK, the target stops driving SDA. A further byte clocked by the host therefore reads as 0xFF.
- R10: A START or STOP in the middle of a byte aborts the transfer with no strobe. The next transaction then behaves normally.
- R11: The target acknowledges each accepted byte (matched address, command, data) by holding `sda_oe` high while SCL is high on the ninth clock. Out of reset, `sda_oe`, `reg_wr` and `reg_rd` are 0.
- R12: `reg_wr` and `reg_rd` are each one cycle wide and are never high together. Each write transaction gives exactly one `reg_wr` and each read gives exactly one `reg_rd`.
- R13: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pin level, asynchronous |
| sda_i | input | 1 | SDA pin level, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 6 | Register index from the command byte |
| reg_wdata | output | 16 | Write data, valid while reg_wr is high |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_rdata | input | 16 | Read data, sampled while reg_rd is high |
| reg_rd | output | 1 | Register read strobe, one cycle |

## Verification
The assertions check four properties on every cycle. Both strobes are single-cycle and never overlap. The open-drain enable changes only while the synchronized SCL is low. Any START or STOP leaves SDA released and suppresses the write strobe. Only the bench scenarios can show the transaction-level behaviour: address matching and broadcast, command decoding, byte order in each direction, a host NACK ending a read, and mid-byte aborts. The bench checks these with lines skewed randomly by one clock against a register model it keeps itself.

// File: rtl/dbgreg_i2c_pkg.sv
package dbgreg_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WDATA,
    PH_RDATA
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizer chain for one bus line, plus one extra stage for edge detection.
module i2c_line_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/i2c_bus_events.sv
// Synchronizes SCL/SDA and flags START and STOP conditions.
module i2c_bus_events #(
  parameter int SYNC_STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_prev,
  output logic sda_lvl,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] raw, now, prev;
  logic       sda_prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .d      (raw[g]),
      .q      (now[g]),
      .q_prev (prev[g])
    );
  end

  assign scl_lvl  = now[0];
  assign scl_prev = prev[0];
  assign sda_lvl  = now[1];
  assign sda_prev = prev[1];

  // SDA moving while SCL is stable high on both sampled stages
  assign start_ev = scl_lvl & scl_prev &  sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev &  sda_lvl;
endmodule

// File: rtl/dbgreg_i2c_target.sv
module dbgreg_i2c_target
  import dbgreg_i2c_pkg::*;
#(
  parameter int                SYNC_STAGES = 3,
  parameter int                BYTE_W      = 8,
  parameter int                IDX_W       = 6,
  parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'h45,
  parameter logic [BYTE_W-2:0] BCAST_ADDR  = 7'h67
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [IDX_W-1:0]      reg_addr,
  output logic [2*BYTE_W-1:0]   reg_wdata,
  output logic                  reg_wr,
  input  logic [2*BYTE_W-1:0]   reg_rdata,
  output logic                  reg_rd
);
  localparam int                CNT_W    = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]  ACK_BIT  = CNT_W'(BYTE_W + 1);
  localparam int                WR_FLAG  = BYTE_W - 1;
  localparam int                NARROW   = BYTE_W - 2;

  logic scl_lvl, scl_prev, sda_lvl, start_ev, stop_ev;
  logic scl_rise, scl_fall;

  i2c_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_ev (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .scl_prev (scl_prev),
    .sda_lvl  (sda_lvl),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  assign scl_rise =  scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl &  scl_prev;

  phase_e              phase;
  logic [CNT_W-1:0]    bitcnt;
  logic [BYTE_W-1:0]   shreg, lo_hold, hi_hold;
  logic                rw_q, narrow_q, byte_sel, host_ack, load_pend;
  logic                sda_oe_q, reg_wr_q, reg_rd_q;
  logic [IDX_W-1:0]    reg_addr_q;
  logic [2*BYTE_W-1:0] reg_wdata_q;
  logic                addr_hit;

  assign addr_hit = (shreg[BYTE_W-1:1] == DEV_ADDR) ||
                    ((shreg[BYTE_W-1:1] == BCAST_ADDR) && !shreg[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      lo_hold     <= '0;
      hi_hold     <= '0;
      rw_q        <= 1'b0;
      narrow_q    <= 1'b0;
      byte_sel    <= 1'b0;
      host_ack    <= 1'b0;
      load_pend   <= 1'b0;
      sda_oe_q    <= 1'b0;
      reg_wr_q    <= 1'b0;
      reg_rd_q    <= 1'b0;
      reg_addr_q  <= '0;
      reg_wdata_q <= '0;
    end else begin
      reg_wr_q <= 1'b0;
      reg_rd_q <= 1'b0;
      if (load_pend) begin
        // reg_rd is high in this cycle: capture read data, present its MSB
        load_pend <= 1'b0;
        shreg     <= reg_rdata[BYTE_W-1:0];
        hi_hold   <= reg_rdata[2*BYTE_W-1:BYTE_W];
        sda_oe_q  <= ~reg_rdata[BYTE_W-1];
      end
      if (start_ev) begin
        phase     <= PH_ADDR;
        bitcnt    <= '0;
        sda_oe_q  <= 1'b0;
        load_pend <= 1'b0;
      end else if (stop_ev) begin
        phase     <= PH_IDLE;
        sda_oe_q  <= 1'b0;
        load_pend <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt < LAST_BIT) begin
            if (phase != PH_RDATA) shreg <= {shreg[BYTE_W-2:0], sda_lvl};
          end else begin
            host_ack <= ~sda_lvl;
          end
        end else if (scl_fall) begin
          if (bitcnt == LAST_BIT) begin
            // start of the ninth clock
            case (phase)
              PH_ADDR: begin
                if (addr_hit) begin
                  sda_oe_q <= 1'b1;
                  rw_q     <= shreg[0];
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_RDATA: sda_oe_q <= 1'b0;
              default:  sda_oe_q <= 1'b1;
            endcase
          end else if (bitcnt == ACK_BIT) begin
            // end of the ninth clock
            bitcnt   <= '0;
            sda_oe_q <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (rw_q) begin
                  phase     <= PH_RDATA;
                  byte_sel  <= 1'b0;
                  reg_rd_q  <= 1'b1;
                  load_pend <= 1'b1;
                end else begin
                  phase <= PH_CMD;
                end
              end
              PH_CMD: begin
                reg_addr_q <= shreg[IDX_W-1:0];
                narrow_q   <= shreg[NARROW];
                byte_sel   <= 1'b0;
                phase      <= shreg[WR_FLAG] ? PH_WDATA : PH_IDLE;
              end
              PH_WDATA: begin
                if (narrow_q || byte_sel) begin
                  reg_wdata_q <= narrow_q ? {{BYTE_W{1'b0}}, shreg} : {shreg, lo_hold};
                  reg_wr_q    <= 1'b1;
                  phase       <= PH_IDLE;
                end else begin
                  lo_hold  <= shreg;
                  byte_sel <= 1'b1;
                end
              end
              PH_RDATA: begin
                if (host_ack && !narrow_q && !byte_sel) begin
                  byte_sel <= 1'b1;
                  shreg    <= hi_hold;
                  sda_oe_q <= ~hi_hold[BYTE_W-1];
                end else begin
                  phase <= PH_IDLE;
                end
              end
              default: phase <= PH_IDLE;
            endcase
          end else if (phase == PH_RDATA) begin
            sda_oe_q <= ~shreg[BYTE_W-2];
            shreg    <= {shreg[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe    = sda_oe_q;
  assign reg_addr  = reg_addr_q;
  assign reg_wdata = reg_wdata_q;
  assign reg_wr    = reg_wr_q;
  assign reg_rd    = reg_rd_q;
endmodule

// File: rtl/dbgreg_i2c_target_chk.sv
module dbgreg_i2c_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_lvl,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic reg_wr,
  input logic reg_rd
);
  // R12
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);
  // R12
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
  // R13
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));
  // R10
  cond_release_chk: assert property (@(posedge clk) disable iff (rst)
    (start_ev || stop_ev) |=> (!sda_oe && !reg_wr));
endmodule

bind dbgreg_i2c_target dbgreg_i2c_target_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_lvl  (scl_lvl),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_oe   (sda_oe),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd)
);

// File: tb/sim_dbgreg_i2c_target.sv
module sim_dbgreg_i2c_target;
  localparam int Q = 8;  // clocks per quarter bit

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        host_scl = 1'b1, host_sda = 1'b1;
  logic        scl_d = 1'b1, sda_d = 1'b1, sk_scl = 1'b0, sk_sda = 1'b0;
  logic        scl_bus, sda_bus, host_sda_eff;
  logic        sda_oe, reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] mem [64];

  int n_cmp = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_bad = 0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;

  // R1: each line randomly delayed by zero or one clock
  always @(posedge clk) begin
    scl_d  <= host_scl;
    sda_d  <= host_sda;
    sk_scl <= 1'($urandom_range(1));
    sk_sda <= 1'($urandom_range(1));
  end
  assign scl_bus      = sk_scl ? scl_d : host_scl;
  assign host_sda_eff = sk_sda ? sda_d : host_sda;
  assign sda_bus      = host_sda_eff & ~sda_oe;
  assign reg_rdata    = mem[reg_addr];

  dbgreg_i2c_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .reg_rd(reg_rd)
  );

  // register bank model and port monitor (sole writer of mem)
  initial begin
    logic oe_last;
    oe_last = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 40503) ^ 16'h5a5a;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (reg_wr) begin
          wr_cnt++;
          wr_addr = reg_addr;
          wr_data = reg_wdata;
          mem[reg_addr] = reg_wdata;
        end
        if (reg_rd) rd_cnt++;
        if (sda_oe != oe_last && scl_bus) oe_bad++;
      end
      oe_last = sda_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask
  task automatic i2c_start();
    host_sda = 1'b1; qw(); host_scl = 1'b1; qw(); host_sda = 1'b0; qw(); host_scl = 1'b0; qw();
  endtask
  task automatic i2c_stop();
    host_sda = 1'b0; qw(); host_scl = 1'b1; qw(); host_sda = 1'b1; qw(); qw();
  endtask
  task automatic wr_bit(input logic b);
    host_sda = b; qw(); host_scl = 1'b1; qw(); qw(); host_scl = 1'b0; qw();
  endtask
  task automatic rd_bit(output logic b);
    host_sda = 1'b1; qw(); host_scl = 1'b1; qw(); b = sda_bus; qw(); host_scl = 1'b0; qw();
  endtask
  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(b);
    acked = !b;
  endtask
  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rd_bit(b); v[i] = b; end
    wr_bit(!give_ack);
  endtask

  task automatic reg_write(input logic [6:0] dev, input logic [5:0] idx, input logic narrow,
                           input logic [15:0] data, output int acks);
    logic a;
    acks = 0;
    i2c_start();
    send_byte({dev, 1'b0}, a);       acks += int'(a);
    send_byte({1'b1, narrow, idx}, a); acks += int'(a);
    send_byte(data[7:0], a);         acks += int'(a);
    if (!narrow) begin send_byte(data[15:8], a); acks += int'(a); end
    i2c_stop();
  endtask

  task automatic reg_read(input logic [6:0] dev, input logic [5:0] idx, input logic narrow,
                          input logic use_stop, output logic [15:0] val, output int acks);
    logic a;
    logic [7:0] lo, hi;
    acks = 0; hi = 8'h00;
    i2c_start();
    send_byte({dev, 1'b0}, a);         acks += int'(a);
    send_byte({1'b0, narrow, idx}, a); acks += int'(a);
    if (use_stop) i2c_stop();
    i2c_start();
    send_byte({dev, 1'b1}, a);         acks += int'(a);
    recv_byte(lo, !narrow);
    if (!narrow) recv_byte(hi, 1'b0);
    i2c_stop();
    val = {hi, lo};
  endtask

  initial begin
    int acks, w0, r0;
    logic a;
    logic [15:0] v, exp16;
    logic [7:0] b8;
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R11 reset outputs",
        {sda_oe, reg_wr, reg_rd}, 0);

    // R2 R6 R7: 16-bit write
    w0 = wr_cnt; r0 = rd_cnt;
    reg_write(7'h45, 6'd5, 1'b0, 16'hBEEF, acks);
    chk(acks == 4, "R2/R11 write acks", acks, 4);
    chk(wr_cnt == w0 + 1 && rd_cnt == r0, "R12 one write strobe", wr_cnt - w0, 1);
    chk(wr_addr == 6'd5, "R5 write index", wr_addr, 5);
    chk(wr_data == 16'hBEEF, "R6 R7 wide write data", wr_data, 16'hBEEF);

    // R5 R6: 8-bit write
    reg_write(7'h45, 6'h2A, 1'b1, 16'h337E, acks);
    chk(acks == 3, "R11 narrow write acks", acks, 3);
    chk(wr_data == 16'h007E && wr_addr == 6'h2A, "R5 R6 narrow write", wr_data, 16'h007E);

    // R8: 16-bit read with STOP between phases
    r0 = rd_cnt;
    reg_read(7'h45, 6'd5, 1'b0, 1'b1, v, acks);
    chk(v == 16'hBEEF, "R8 wide read", v, 16'hBEEF);
    chk(acks == 3 && rd_cnt == r0 + 1, "R2 R12 read acks/strobe", acks, 3);
    chk(reg_addr == 6'd5, "R5 address held", reg_addr, 5);

    // R8: 8-bit read with repeated START
    reg_read(7'h45, 6'h2A, 1'b1, 1'b0, v, acks);
    chk(v == 16'h007E, "R8 narrow read", v, 16'h007E);
    repeat (8) @(negedge clk);
    chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);

    // R3: address mismatch
    w0 = wr_cnt; r0 = rd_cnt;
    reg_write(7'h22, 6'd7, 1'b0, 16'h1111, acks);
    chk(acks == 0, "R3 no ack on mismatch", acks, 0);
    chk(wr_cnt == w0 && rd_cnt == r0, "R3 no strobe on mismatch", wr_cnt - w0, 0);

    // R4: broadcast write and read
    reg_write(7'h67, 6'd9, 1'b0, 16'h1234, acks);
    chk(acks == 4 && wr_data == 16'h1234 && wr_addr == 6'd9, "R4 broadcast write", wr_data, 16'h1234);
    r0 = rd_cnt;
    i2c_start(); send_byte({7'h67, 1'b1}, a); i2c_stop();
    chk(!a && rd_cnt == r0, "R4 broadcast read refused", {a, 8'(rd_cnt - r0)}, 0);

    // R10: abort by START in the high byte, then by STOP in the low byte
    w0 = wr_cnt;
    i2c_start(); send_byte({7'h45, 1'b0}, a); send_byte({2'b10, 6'd3}, a);
    send_byte(8'hA5, a);
    for (int i = 0; i < 4; i++) wr_bit(i[0]);
    i2c_start(); i2c_stop();
    chk(wr_cnt == w0, "R10 abort by START", wr_cnt - w0, 0);
    i2c_start(); send_byte({7'h45, 1'b0}, a); send_byte({2'b10, 6'd3}, a);
    for (int i = 0; i < 3; i++) wr_bit(1'b1);
    i2c_stop();
    chk(wr_cnt == w0, "R10 abort by STOP", wr_cnt - w0, 0);
    reg_write(7'h45, 6'd3, 1'b0, 16'h0F0F, acks);
    chk(acks == 4 && wr_data == 16'h0F0F, "R10 recovery write", wr_data, 16'h0F0F);

    // R6 R11: extra byte after narrow write not acked
    w0 = wr_cnt;
    i2c_start(); send_byte({7'h45, 1'b0}, a); send_byte({2'b11, 6'd12}, a);
    send_byte(8'h81, a); send_byte(8'h55, a); i2c_stop();
    chk(!a && wr_cnt == w0 + 1 && wr_data == 16'h0081, "R6 extra byte refused", wr_data, 16'h0081);

    // R9: host acks last byte of narrow read, next byte reads as 0xFF
    i2c_start(); send_byte({7'h45, 1'b0}, a); send_byte({2'b01, 6'd12}, a);
    i2c_start(); send_byte({7'h45, 1'b1}, a);
    recv_byte(b8, 1'b1);
    chk(b8 == 8'h81, "R8 narrow read data", b8, 8'h81);
    recv_byte(b8, 1'b0); i2c_stop();
    chk(b8 == 8'hFF, "R9 released after last byte", b8, 8'hFF);

    // R1 R7: random write / read-back under skew
    for (int it = 0; it < 20; it++) begin
      logic [5:0]  idx;
      logic        nar;
      logic [15:0] d;
      idx = 6'($urandom_range(63));
      nar = 1'($urandom_range(1));
      d   = 16'($urandom);
      exp16 = nar ? {8'h00, d[7:0]} : d;
      reg_write(7'h45, idx, nar, d, acks);
      chk(wr_data == exp16 && wr_addr == idx, "R1 R6 random write", wr_data, exp16);
      reg_read(7'h45, idx, nar, 1'($urandom_range(1)), v, acks);
      chk(v == exp16, "R1 R7 R8 random read-back", v, exp16);
    end

    chk(oe_bad == 0, "R13 sda_oe moved while SCL high", oe_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule